// File: doc/BRIEF.md
# Interruptible GPIO Port Controller

This block is one 8-bit general-purpose I/O port. Software reaches it through a small register bus: a write strobe, a 4-bit address, 8-bit write data and an 8-bit read data path that always reflects the addressed register. Every register holds one bit per pin. The registers cover the pin function, the direction, the output value, the pull-resistor enable, the interrupt enable, the edge choice and the interrupt flags. A read-only view shows the synchronized pin levels.

The block synchronizes each pad input through two flops. It detects the chosen edge on every pin that is under port control and latches that event in a sticky flag. It raises one combined interrupt request. Toward the pad it drives an output enable, an output value, pull-up and pull-down controls and a two-bit function code for each pin. The analog pad, the peripherals that take over pins and the CPU's interrupt vectoring sit outside the block.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every writable register, the flags, the pad controls (oe, out, pull-up, pull-down, function code) and the interrupt request are all 0.
- R2: The register addresses are: 0 pin input, 1 output, 2 direction, 3 pull enable, 4 function bit A, 5 function bit B, 6 interrupt enable, 7 edge select, 8 flags. Any other address reads 0. A write at a writable address replaces that register, and reads return its contents in the same cycle.
- R3: Address 0 returns the pin levels after a two-flop synchronizer, so a change shows up two clock edges after it appears at the pin. Writes to address 0 change nothing.
- R4: A pin with function code 00 and direction bit 1 has its output enable set, and its pad output equals its output-register bit. With direction 0, the output enable and the pad output are both 0.
- R5: A port pin with direction 0 and its pull enable set drives pull-up when its output bit is 1 and pull-down when the bit is 0. With the pull enable clear, neither pull is on.
- R6: A port pin with direction 1 and its pull enable set is driven as an output, and neither pull is on.
- R7: The pad function code of pin i is {B[i], A[i]} on bits 2i+1..2i: 00 port, 01 primary peripheral, 10 reserved, 11 secondary peripheral. For any nonzero code the block drives 0 on that pin's output enable, pad output and pulls.
- R8: An edge-select bit of 0 sets the pin's flag on a low-to-high transition, and a bit of 1 sets it on a high-to-low transition. The flag reads 1 three clock edges after the pin changes.
- R9: A transition in the direction opposite to the selected one leaves the flag unchanged.
- R10: A pin with a nonzero function code never sets its flag from a pin transition.
- R11: A write to address 8 loads the flags. Writing a 1 sets that flag, which produces a software interrupt.
- R12: Hardware never clears a flag; only a write of 0 clears it. When a detected edge and a write of 0 to the same flag fall in the same cycle, the flag ends at 1.
- R13: The interrupt request is 1 exactly when some pin has both its flag and its enable bit at 1. Each enable bit masks only its own pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| pin_i | input | 8 | Pad input levels |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_out_o | output | 8 | Per-pin output value |
| pad_pu_o | output | 8 | Per-pin pull-up enable |
| pad_pd_o | output | 8 | Per-pin pull-down enable |
| pad_func_o | output | 16 | Two-bit function code per pin |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench checks synchronizer latency edge by edge. A design with one flop too few or too many would show a new pin level, or set a flag, one cycle early or late. It drives edges against the opposite edge-select setting and on pins handed to a peripheral, where a careless design would set flags anyway. It sets up the illegal output-plus-pull case, where a naive decode would turn on a pull while driving the pin. It also lines up a hardware edge with a software clear in the same cycle: a design that gives the write priority would lose the event and read back 0.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_PIN   = 4'd0,
    REG_OUT   = 4'd1,
    REG_DIR   = 4'd2,
    REG_PULL  = 4'd3,
    REG_FSA   = 4'd4,
    REG_FSB   = 4'd5,
    REG_IEN   = 4'd6,
    REG_EDGE  = 4'd7,
    REG_FLAG  = 4'd8
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] smp_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] meta_q, smp_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      smp_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      smp_q  <= meta_q;
      prev_q <= smp_q;
    end
  end

  assign smp_o  = smp_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] smp_i,
  input  logic [WIDTH-1:0] prev_i,
  input  logic [WIDTH-1:0] fall_sel_i,
  input  logic [WIDTH-1:0] port_mask_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] flag_q, flag_d, hit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      if (fall_sel_i[i]) hit[i] = prev_i[i] & ~smp_i[i] & port_mask_i[i];
      else               hit[i] = ~prev_i[i] & smp_i[i] & port_mask_i[i];
    end
  end

  // A detected edge overrides a software clear in the same cycle.
  always_comb begin
    if (wr_i) flag_d = wdata_i | hit;
    else      flag_d = flag_q | hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R12: without a write, no flag ever falls
  assert_flag_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (($past(flag_q) & ~flag_q) == '0));

  // R10: without a write, a pin owned by a peripheral never gains a flag
  assert_periph_no_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((flag_q & ~$past(flag_q) & ~$past(port_mask_i)) == '0));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]   fsa_i,
  input  logic [WIDTH-1:0]   fsb_i,
  input  logic [WIDTH-1:0]   dir_i,
  input  logic [WIDTH-1:0]   out_i,
  input  logic [WIDTH-1:0]   pull_i,
  output logic [WIDTH-1:0]   port_mask_o,
  output logic [WIDTH-1:0]   oe_o,
  output logic [WIDTH-1:0]   dout_o,
  output logic [WIDTH-1:0]   pu_o,
  output logic [WIDTH-1:0]   pd_o,
  output logic [2*WIDTH-1:0] func_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic is_port, in_pull;
    assign is_port        = ~(fsa_i[i] | fsb_i[i]);
    assign in_pull        = is_port & ~dir_i[i] & pull_i[i];
    assign port_mask_o[i] = is_port;
    assign oe_o[i]        = is_port & dir_i[i];
    assign dout_o[i]      = is_port & dir_i[i] & out_i[i];
    assign pu_o[i]        = in_pull & out_i[i];
    assign pd_o[i]        = in_pull & ~out_i[i];
    assign func_o[2*i+1:2*i] = {fsb_i[i], fsa_i[i]};
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [PINS-1:0]      bus_wdata_i,
  output logic [PINS-1:0]      bus_rdata_o,
  input  logic [PINS-1:0]      pin_i,
  output logic [PINS-1:0]      pad_oe_o,
  output logic [PINS-1:0]      pad_out_o,
  output logic [PINS-1:0]      pad_pu_o,
  output logic [PINS-1:0]      pad_pd_o,
  output logic [2*PINS-1:0]    pad_func_o,
  output logic                 irq_o
);
  localparam int unsigned FUNC_W = 2 * PINS;

  logic rst_n_s;
  logic [PINS-1:0] out_q, dir_q, pull_q, fsa_q, fsb_q, ien_q, edge_q;
  logic [PINS-1:0] out_d, dir_d, pull_d, fsa_d, fsb_d, ien_d, edge_d;
  logic [PINS-1:0] smp, prev, flag, port_mask;
  logic [FUNC_W-1:0] func;
  logic flag_wr;
  gpio_reg_e addr;

  assign addr = gpio_reg_e'(bus_addr_i);

  gpio_rst_sync u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n_s));

  // Register next-state: clock enable per register written out
  always_comb begin
    out_d  = out_q;
    dir_d  = dir_q;
    pull_d = pull_q;
    fsa_d  = fsa_q;
    fsb_d  = fsb_q;
    ien_d  = ien_q;
    edge_d = edge_q;
    if (bus_wr_i) begin
      case (addr)
        REG_OUT:  out_d  = bus_wdata_i;
        REG_DIR:  dir_d  = bus_wdata_i;
        REG_PULL: pull_d = bus_wdata_i;
        REG_FSA:  fsa_d  = bus_wdata_i;
        REG_FSB:  fsb_d  = bus_wdata_i;
        REG_IEN:  ien_d  = bus_wdata_i;
        REG_EDGE: edge_d = bus_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      fsa_q  <= '0;
      fsb_q  <= '0;
      ien_q  <= '0;
      edge_q <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      pull_q <= pull_d;
      fsa_q  <= fsa_d;
      fsb_q  <= fsb_d;
      ien_q  <= ien_d;
      edge_q <= edge_d;
    end
  end

  assign flag_wr = bus_wr_i && (addr == REG_FLAG);

  gpio_sync #(.WIDTH(PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n_s), .raw_i(pin_i), .smp_o(smp), .prev_o(prev)
  );

  gpio_edge_flags #(.WIDTH(PINS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_n_s), .smp_i(smp), .prev_i(prev),
    .fall_sel_i(edge_q), .port_mask_i(port_mask), .wr_i(flag_wr),
    .wdata_i(bus_wdata_i), .flag_o(flag)
  );

  gpio_pad_ctrl #(.WIDTH(PINS)) u_pad (
    .fsa_i(fsa_q), .fsb_i(fsb_q), .dir_i(dir_q), .out_i(out_q), .pull_i(pull_q),
    .port_mask_o(port_mask), .oe_o(pad_oe_o), .dout_o(pad_out_o),
    .pu_o(pad_pu_o), .pd_o(pad_pd_o), .func_o(func)
  );

  assign pad_func_o = func;

  always_comb begin
    case (addr)
      REG_PIN:  bus_rdata_o = smp;
      REG_OUT:  bus_rdata_o = out_q;
      REG_DIR:  bus_rdata_o = dir_q;
      REG_PULL: bus_rdata_o = pull_q;
      REG_FSA:  bus_rdata_o = fsa_q;
      REG_FSB:  bus_rdata_o = fsb_q;
      REG_IEN:  bus_rdata_o = ien_q;
      REG_EDGE: bus_rdata_o = edge_q;
      REG_FLAG: bus_rdata_o = flag;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o = |(flag & ien_q);

  // R13: a request needs at least one enabled pin
  assert_irq_needs_enable_R13: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    irq_o |-> (ien_q != '0));

  // R5: a pin never pulls both ways
  assert_pull_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (pad_pu_o & pad_pd_o) == '0);

  // R6: a driven pin has no pull
  assert_no_pull_when_driven_R6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (pad_oe_o & (pad_pu_o | pad_pd_o)) == '0);

  // R7: a pin with a nonzero function code gets nothing from the port
  assert_periph_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    ((pad_oe_o | pad_out_o | pad_pu_o | pad_pd_o) & (fsa_q | fsb_q)) == '0);
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [7:0]  wdata = 8'd0;
  logic [7:0]  rdata;
  logic [7:0]  pins = 8'd0;
  logic [7:0]  oe, dout, pu, pd;
  logic [15:0] func;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_port dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins),
    .pad_oe_o(oe), .pad_out_o(dout), .pad_pu_o(pu), .pad_pd_o(pd),
    .pad_func_o(func), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 9; a++) begin
      rd_reg(a[3:0], v);
      check("R1 register reset", {8'h0, v}, 16'h0);
    end
    check("R1 pad reset", {oe | dout | pu | pd, 8'h0}, 16'h0);
    check("R1 func reset", func, 16'h0);
    check("R1 irq reset", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr_reg(4'd1, 8'h3C); wr_reg(4'd3, 8'h5A); wr_reg(4'd7, 8'hC3);
    rd_reg(4'd1, v); check("R2 output readback", {8'h0, v}, 16'h3C);
    rd_reg(4'd3, v); check("R2 pull readback", {8'h0, v}, 16'h5A);
    rd_reg(4'd7, v); check("R2 edge readback", {8'h0, v}, 16'hC3);
    rd_reg(4'd12, v); check("R2 unmapped reads 0", {8'h0, v}, 16'h0);
    wr_reg(4'd1, 8'h00); wr_reg(4'd3, 8'h00); wr_reg(4'd7, 8'h00);
  endtask

  task automatic t_input;
    logic [7:0] v;
    @(negedge clk); pins = 8'hA5;
    idle(3);
    rd_reg(4'd0, v); check("R3 input value", {8'h0, v}, 16'hA5);
    wr_reg(4'd0, 8'h00);
    rd_reg(4'd0, v); check("R3 input write ignored", {8'h0, v}, 16'hA5);
    @(negedge clk); pins = 8'h5A;
    @(negedge clk); rd_reg(4'd0, v); check("R3 one edge: old value", {8'h0, v}, 16'hA5);
    @(negedge clk); rd_reg(4'd0, v); check("R3 two edges: new value", {8'h0, v}, 16'h5A);
    @(negedge clk); pins = 8'h00;
    idle(4);
    wr_reg(4'd8, 8'h00);
    rd_reg(4'd8, v); check("R12 software clear", {8'h0, v}, 16'h0);
  endtask

  task automatic t_drive;
    wr_reg(4'd2, 8'hF0); wr_reg(4'd1, 8'h3C);
    #1 check("R4 output enable", {8'h0, oe}, 16'hF0);
    check("R4 pad output", {8'h0, dout}, 16'h30);
    wr_reg(4'd2, 8'h00); wr_reg(4'd3, 8'h0F); wr_reg(4'd1, 8'h05);
    #1 check("R5 pull-up", {8'h0, pu}, 16'h05);
    check("R5 pull-down", {8'h0, pd}, 16'h0A);
    check("R4 input: no drive", {oe, dout}, 16'h0);
    wr_reg(4'd3, 8'h00);
    #1 check("R5 float", {pu, pd}, 16'h0);
    wr_reg(4'd2, 8'h01); wr_reg(4'd3, 8'h01); wr_reg(4'd1, 8'h01);
    #1 check("R6 illegal combo drives", {oe, dout}, 16'h0101);
    check("R6 illegal combo no pull", {pu, pd}, 16'h0);
    wr_reg(4'd2, 8'hFF); wr_reg(4'd1, 8'hFF);
    wr_reg(4'd4, 8'h06); wr_reg(4'd5, 8'h04);
    #1 check("R7 function code", func, 16'h0034);
    check("R7 peripheral pins released", {oe, dout}, 16'hF9F9);
    wr_reg(4'd4, 8'h00); wr_reg(4'd5, 8'h00); wr_reg(4'd2, 8'h00);
    wr_reg(4'd1, 8'h00); wr_reg(4'd3, 8'h00);
  endtask

  task automatic t_edges;
    logic [7:0] v;
    @(negedge clk); pins[0] = 1'b1;
    idle(2); rd_reg(4'd8, v); check("R8 rising: not yet", {8'h0, v}, 16'h00);
    idle(1); rd_reg(4'd8, v); check("R8 rising sets flag", {8'h0, v}, 16'h01);
    @(negedge clk); pins[0] = 1'b0;
    idle(5); rd_reg(4'd8, v); check("R12 flag held by hardware", {8'h0, v}, 16'h01);
    wr_reg(4'd8, 8'h00);
    wr_reg(4'd7, 8'h02);
    @(negedge clk); pins[1] = 1'b1;
    idle(4); rd_reg(4'd8, v); check("R9 opposite edge ignored", {8'h0, v}, 16'h00);
    @(negedge clk); pins[1] = 1'b0;
    idle(3); rd_reg(4'd8, v); check("R8 falling sets flag", {8'h0, v}, 16'h02);
    wr_reg(4'd8, 8'h00); wr_reg(4'd7, 8'h00);
    wr_reg(4'd4, 8'h04);
    @(negedge clk); pins[2] = 1'b1;
    idle(4); rd_reg(4'd8, v); check("R10 peripheral pin no flag", {8'h0, v}, 16'h00);
    @(negedge clk); pins[2] = 1'b0;
    idle(4); wr_reg(4'd4, 8'h00);
    // edge and software clear in the same cycle
    @(negedge clk); pins[3] = 1'b1;
    idle(2);
    wr = 1'b1; addr = 4'd8; wdata = 8'h00;
    @(negedge clk); wr = 1'b0;
    rd_reg(4'd8, v); check("R12 edge beats clear", {8'h0, v}, 16'h08);
    wr_reg(4'd8, 8'h00);
    rd_reg(4'd8, v); check("R12 later clear works", {8'h0, v}, 16'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr_reg(4'd8, 8'h80);
    rd_reg(4'd8, v); check("R11 software set", {8'h0, v}, 16'h80);
    check("R13 masked: no irq", {15'h0, irq}, 16'h0);
    wr_reg(4'd6, 8'h80);
    #1 check("R13 enabled: irq", {15'h0, irq}, 16'h1);
    wr_reg(4'd6, 8'h40);
    #1 check("R13 other pin enable masks", {15'h0, irq}, 16'h0);
    wr_reg(4'd6, 8'h80); wr_reg(4'd8, 8'h00);
    #1 check("R13 cleared flag drops irq", {15'h0, irq}, 16'h0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_regs();
    t_input();
    t_drive();
    t_edges();
    t_irq();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule